// File: doc/BRIEF.md
# Word FIFO Pair with Self-Clearing Flush

This block sits between a host register port and a serial bus engine and buffers 32-bit words in both directions. Each word carries four bus bytes. The host pushes words into the transmit queue and pops words from the receive queue. The bus engine drains the transmit queue one word at a time and fills the receive queue. Both queues are 8 words deep by default.

A small control register sets two thresholds and holds two flush requests. A flush bit that the host sets empties its queue on the next clock edge and then returns to zero, so software can poll until the bit reads zero. A packed status word reports the free transmit slots and the waiting receive words. Two level outputs tell the interrupt logic when the transmit side wants data and when the receive side has data ready. Two single-cycle pulses flag a host write into a full transmit queue and a host read from an empty receive queue.

Top module: `word_fifo_pair`

## Requirements
- R1: After synchronous reset both queues are empty, the control register reads 0, and the status word reads 0x80 (8 free transmit slots, 0 receive words).
- R2: Words written by the host into the transmit queue leave in write order on `eng_tx_data`. `eng_tx_valid` is high exactly while the queue is not empty, and each `eng_tx_pop` while valid removes one word.
- R3: A host transmit write while the transmit queue holds 8 words is dropped, and `tx_overflow` is high in that same cycle.
- R4: Words pushed by the engine into the receive queue appear in push order on `host_rx_rdata`, and each `host_rx_rd_en` removes one word.
- R5: While the receive queue is empty, `host_rx_rdata` is zero, and a host read raises `rx_underflow` in that cycle without changing the queue.
- R6: Status bits [7:4] give the free transmit slots and bits [3:0] give the used receive words, as of the last clock edge.
- R7: Writing control bit 1 = 1 empties the transmit queue at the following edge. Bit 1 reads 1 for exactly that one cycle, and the receive queue is not affected. Transfers into or out of the transmit queue in that cycle are ignored.
- R8: Writing control bit 0 = 1 empties the receive queue in the same way and leaves the transmit queue intact.
- R9: Control bits [7:5] hold the transmit trigger and bits [4:2] hold the receive trigger, and both read back as written.
- R10: `tx_data_req` is high while free transmit slots >= transmit trigger + 1. `rx_data_req` is high while used receive words >= receive trigger + 1.
- R11: An engine push while the receive queue holds 8 words is dropped. `eng_rx_ready` is low exactly while the receive queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 8 | Control value: {tx trigger, rx trigger, tx flush, rx flush} |
| cfg_rdata | output | 8 | Control register readback |
| fifo_status | output | 8 | {free tx slots, used rx words} |
| host_tx_wr_en | input | 1 | Host pushes a word into the transmit queue |
| host_tx_wdata | input | 32 | Word to transmit |
| host_rx_rd_en | input | 1 | Host pops the head of the receive queue |
| host_rx_rdata | output | 32 | Head of the receive queue, zero when empty |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_tx_data | output | 32 | Head of the transmit queue |
| eng_rx_push | input | 1 | Engine pushes a received word |
| eng_rx_data | input | 32 | Received word |
| eng_rx_ready | output | 1 | Receive queue has room |
| tx_data_req | output | 1 | Transmit trigger level met |
| rx_data_req | output | 1 | Receive trigger level met |
| tx_overflow | output | 1 | Host write into a full transmit queue (dropped) |
| rx_underflow | output | 1 | Host read from an empty receive queue |

## Verification
The queues are first driven with short ordered bursts that separate correct ordering from pointer slips. Then come fill-past-capacity bursts that show whether a dropped word corrupts the head or the counts. Simultaneous push and pop while the queue is full and while it is empty show whether a queue judges full and empty from the pre-edge state. Flushes are issued while the opposite queue holds data, which shows that each flush bit reaches only its own queue and clears after one cycle. Trigger sweeps at several levels catch off-by-one errors in the N+1 threshold. A long pseudo-random mix of all strobes with periodic flushes is compared against a queue-based model on every cycle.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;

    // Bit positions inside the control register that the queues decode
    localparam int unsigned CTL_RX_FLUSH_BIT = 0;
    localparam int unsigned CTL_TX_FLUSH_BIT = 1;
    localparam int unsigned CTL_RX_TRIG_LSB  = 2;

    typedef struct packed {
        logic tx;
        logic rx;
    } flush_req_t;

    // A trigger field value of N means a threshold of N+1 words
    function automatic logic level_met(input int unsigned have,
                                       input int unsigned trig);
        return have >= (trig + 1);
    endfunction

endpackage

// File: rtl/wfifo_store.sv
module wfifo_store #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] used
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, empty, push_ok, pop_ok;

    assign full    = (used == FULL_CNT);
    assign empty   = (used == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign rdata   = empty ? '0 : mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push_ok, pop_ok})
                2'b10:   used <= used + 1'b1;
                2'b01:   used <= used - 1'b1;
                default: used <= used;
            endcase
        end
    end

    // R6: occupancy never exceeds the depth
    assert_used_bounded_R6: assert property (@(posedge clk) disable iff (rst)
        used <= FULL_CNT);

    // R6: occupancy moves by at most one word per cycle unless flushed
    assert_used_step_R6: assert property (@(posedge clk) disable iff (rst)
        !flush |=> (used <= $past(used) + 1'b1) && (used + 1'b1 >= $past(used)));

endmodule

// File: rtl/wfifo_ctl_reg.sv
module wfifo_ctl_reg
    import wfifo_pkg::*;
#(
    parameter int unsigned TRIG_W = 3,
    parameter int unsigned CTL_W  = 2 + 2 * TRIG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  wdata,
    output logic [CTL_W-1:0]  ctl_q,
    output flush_req_t        flush,
    output logic [TRIG_W-1:0] tx_trig,
    output logic [TRIG_W-1:0] rx_trig
);
    localparam int unsigned TX_TRIG_LSB = CTL_RX_TRIG_LSB + TRIG_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q <= wdata;
        end else begin
            // flush requests last one cycle, then read back as zero
            ctl_q[CTL_TX_FLUSH_BIT] <= 1'b0;
            ctl_q[CTL_RX_FLUSH_BIT] <= 1'b0;
        end
    end

    assign flush.tx = ctl_q[CTL_TX_FLUSH_BIT];
    assign flush.rx = ctl_q[CTL_RX_FLUSH_BIT];
    assign rx_trig  = ctl_q[CTL_RX_TRIG_LSB +: TRIG_W];
    assign tx_trig  = ctl_q[TX_TRIG_LSB +: TRIG_W];

    // R9: trigger fields hold their value when no write arrives
    assert_trig_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(tx_trig) && $stable(rx_trig));

endmodule

// File: rtl/word_fifo_pair.sv
module word_fifo_pair
    import wfifo_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned TRIG_W = $clog2(DEPTH),
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1),
    parameter int unsigned CTL_W  = 2 + 2 * TRIG_W,
    parameter int unsigned STAT_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [CTL_W-1:0]  cfg_wdata,
    output logic [CTL_W-1:0]  cfg_rdata,
    output logic [STAT_W-1:0] fifo_status,
    input  logic              host_tx_wr_en,
    input  logic [WORD_W-1:0] host_tx_wdata,
    input  logic              host_rx_rd_en,
    output logic [WORD_W-1:0] host_rx_rdata,
    input  logic              eng_tx_pop,
    output logic              eng_tx_valid,
    output logic [WORD_W-1:0] eng_tx_data,
    input  logic              eng_rx_push,
    input  logic [WORD_W-1:0] eng_rx_data,
    output logic              eng_rx_ready,
    output logic              tx_data_req,
    output logic              rx_data_req,
    output logic              tx_overflow,
    output logic              rx_underflow
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    flush_req_t        flush;
    logic [TRIG_W-1:0] tx_trig, rx_trig;
    logic [CNT_W-1:0]  tx_used, rx_used, tx_free;

    wfifo_ctl_reg #(.TRIG_W(TRIG_W), .CTL_W(CTL_W)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wdata   (cfg_wdata),
        .ctl_q   (cfg_rdata),
        .flush   (flush),
        .tx_trig (tx_trig),
        .rx_trig (rx_trig)
    );

    wfifo_store #(.W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .flush (flush.tx),
        .push  (host_tx_wr_en),
        .wdata (host_tx_wdata),
        .pop   (eng_tx_pop),
        .rdata (eng_tx_data),
        .used  (tx_used)
    );

    wfifo_store #(.W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .flush (flush.rx),
        .push  (eng_rx_push),
        .wdata (eng_rx_data),
        .pop   (host_rx_rd_en),
        .rdata (host_rx_rdata),
        .used  (rx_used)
    );

    assign tx_free      = FULL_CNT - tx_used;
    assign fifo_status  = {tx_free, rx_used};
    assign eng_tx_valid = (tx_used != '0);
    assign eng_rx_ready = (rx_used != FULL_CNT);
    assign tx_overflow  = host_tx_wr_en && (tx_used == FULL_CNT);
    assign rx_underflow = host_rx_rd_en && (rx_used == '0);
    assign tx_data_req  = level_met(int'(tx_free), int'(tx_trig));
    assign rx_data_req  = level_met(int'(rx_used), int'(rx_trig));

    // R3: a write into a full transmit queue never raises its occupancy
    assert_tx_drop_R3: assert property (@(posedge clk) disable iff (rst)
        tx_overflow |=> tx_used <= $past(tx_used));

    // R11: an engine push into a full receive queue never raises its occupancy
    assert_rx_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (eng_rx_push && !eng_rx_ready) |=> rx_used <= $past(rx_used));

    // R5: an underflowing read sees a zero word
    assert_rx_zero_R5: assert property (@(posedge clk) disable iff (rst)
        rx_underflow |-> host_rx_rdata == '0);

    // R7: a transmit flush leaves the queue empty and the bit clear
    assert_tx_flush_R7: assert property (@(posedge clk) disable iff (rst)
        (flush.tx && !cfg_wr_en) |=> (tx_used == '0) && !cfg_rdata[CTL_TX_FLUSH_BIT]);

    // R8: a receive flush leaves the queue empty
    assert_rx_flush_R8: assert property (@(posedge clk) disable iff (rst)
        flush.rx |=> rx_used == '0);

endmodule

// File: tb/test_word_fifo_pair.sv
`timescale 1ns/1ps
module test_word_fifo_pair;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic [7:0]  fifo_status;
    logic        host_tx_wr_en;
    logic [31:0] host_tx_wdata;
    logic        host_rx_rd_en;
    logic [31:0] host_rx_rdata;
    logic        eng_tx_pop;
    logic        eng_tx_valid;
    logic [31:0] eng_tx_data;
    logic        eng_rx_push;
    logic [31:0] eng_rx_data;
    logic        eng_rx_ready;
    logic        tx_data_req, rx_data_req, tx_overflow, rx_underflow;

    always #4 clk = ~clk;

    word_fifo_pair i_word_fifo_pair (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .fifo_status(fifo_status),
        .host_tx_wr_en(host_tx_wr_en), .host_tx_wdata(host_tx_wdata),
        .host_rx_rd_en(host_rx_rd_en), .host_rx_rdata(host_rx_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_ready(eng_rx_ready),
        .tx_data_req(tx_data_req), .rx_data_req(rx_data_req),
        .tx_overflow(tx_overflow), .rx_underflow(rx_underflow)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;
    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    logic [7:0]  m_ctl;
    logic [31:0] seq;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        cfg_wr_en = 0; cfg_wdata = 0; host_tx_wr_en = 0; host_tx_wdata = 0;
        host_rx_rd_en = 0; eng_tx_pop = 0; eng_rx_push = 0; eng_rx_data = 0;
    endtask

    // Compare all outputs against the behavioural model
    task automatic compare();
        int tsz, rsz;
        tsz = txq.size();
        rsz = rxq.size();
        check("R9 cfg_rdata", 32'(cfg_rdata), 32'(m_ctl));
        check("R6 status", 32'(fifo_status), 32'({4'(8 - tsz), 4'(rsz)}));
        check("R2 tx_valid", 32'(eng_tx_valid), 32'(tsz > 0));
        if (tsz > 0) check("R2 tx_data", eng_tx_data, txq[0]);
        check("R4 R5 rx_rdata", host_rx_rdata, (rsz > 0) ? rxq[0] : 32'd0);
        check("R10 tx_req", 32'(tx_data_req), 32'((8 - tsz) >= int'(m_ctl[7:5]) + 1));
        check("R10 rx_req", 32'(rx_data_req), 32'(rsz >= int'(m_ctl[4:2]) + 1));
        check("R3 overflow", 32'(tx_overflow), 32'(host_tx_wr_en && tsz == 8));
        check("R5 underflow", 32'(rx_underflow), 32'(host_rx_rd_en && rsz == 0));
        check("R11 rx_ready", 32'(eng_rx_ready), 32'(rsz < 8));
    endtask

    // Advance the model by one clock edge using pre-edge state
    task automatic model_edge();
        int tsz, rsz;
        tsz = txq.size();
        rsz = rxq.size();
        if (m_ctl[1]) txq.delete();
        else begin
            if (eng_tx_pop && tsz > 0) void'(txq.pop_front());
            if (host_tx_wr_en && tsz < 8) txq.push_back(host_tx_wdata);
        end
        if (m_ctl[0]) rxq.delete();
        else begin
            if (host_rx_rd_en && rsz > 0) void'(rxq.pop_front());
            if (eng_rx_push && rsz < 8) rxq.push_back(eng_rx_data);
        end
        if (cfg_wr_en) m_ctl = cfg_wdata;
        else m_ctl[1:0] = 2'b00;
    endtask

    task automatic step();
        #1 compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        idle();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        idle();
        m_ctl = 0;
        seq = 32'h1234_5678;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        check("R1 status", 32'(fifo_status), 32'h80);
        check("R1 cfg", 32'(cfg_rdata), 32'h0);
        check("R1 tx_valid", 32'(eng_tx_valid), 32'h0);
        check("R1 rx_rdata", host_rx_rdata, 32'h0);
        @(negedge clk);

        // R2: short ordered burst then drain
        for (int i = 0; i < 3; i++) begin
            host_tx_wr_en = 1; host_tx_wdata = 32'hA000_0000 + i; step();
        end
        for (int i = 0; i < 3; i++) begin
            eng_tx_pop = 1; step();
        end
        eng_tx_pop = 1; step();   // pop on empty is ignored

        // R3: fill past capacity
        for (int i = 0; i < 10; i++) begin
            host_tx_wr_en = 1; host_tx_wdata = 32'hB000_0000 + i; step();
        end
        check("R3 head kept", eng_tx_data, 32'hB000_0000);
        // simultaneous push and pop while full: push refused, pop taken
        for (int i = 0; i < 4; i++) begin
            host_tx_wr_en = 1; host_tx_wdata = 32'hC000_0000 + i; eng_tx_pop = 1; step();
        end

        // R9 R10: transmit trigger 3 -> needs 4 free; drain while watching
        cfg_wr_en = 1; cfg_wdata = {3'd3, 3'd0, 2'b00}; step();
        check("R9 tx trig readback", 32'(cfg_rdata), 32'h60);
        for (int i = 0; i < 9; i++) begin
            eng_tx_pop = 1; step();
        end
        // simultaneous push and pop while empty: push taken only
        host_tx_wr_en = 1; host_tx_wdata = 32'hD0; eng_tx_pop = 1; step();
        eng_tx_pop = 1; step();

        // R4: receive order
        for (int i = 0; i < 5; i++) begin
            eng_rx_push = 1; eng_rx_data = 32'hE000_0000 + i; step();
        end
        host_rx_rd_en = 1; step();

        // R7: flush transmit while receive holds data
        for (int i = 0; i < 4; i++) begin
            host_tx_wr_en = 1; host_tx_wdata = 32'hF000_0000 + i; step();
        end
        cfg_wr_en = 1; cfg_wdata = {3'd3, 3'd1, 2'b10}; step();
        check("R7 bit set", 32'(cfg_rdata[1]), 32'h1);
        host_tx_wr_en = 1; host_tx_wdata = 32'h77; step();  // ignored during flush
        check("R7 tx empty", 32'(fifo_status[7:4]), 32'd8);
        check("R7 bit clear", 32'(cfg_rdata[1]), 32'h0);
        check("R7 rx kept", 32'(fifo_status[3:0]), 32'd4);

        // R8: flush receive while transmit holds data
        host_tx_wr_en = 1; host_tx_wdata = 32'h99; step();
        cfg_wr_en = 1; cfg_wdata = {3'd3, 3'd1, 2'b01}; step();
        step();
        check("R8 rx empty", 32'(fifo_status[3:0]), 32'd0);
        check("R8 tx kept", 32'(fifo_status[7:4]), 32'd7);
        check("R8 bit clear", 32'(cfg_rdata[0]), 32'h0);

        // R5: read while empty
        host_rx_rd_en = 1; step();

        // R11 R10: receive trigger 6 -> 7 words; overfill
        cfg_wr_en = 1; cfg_wdata = {3'd7, 3'd6, 2'b00}; step();
        for (int i = 0; i < 10; i++) begin
            eng_rx_push = 1; eng_rx_data = 32'h5500_0000 + i; step();
        end
        check("R11 rx head kept", host_rx_rdata, 32'h5500_0000);
        for (int i = 0; i < 9; i++) begin
            host_rx_rd_en = 1; step();
        end

        // Mixed pseudo-random traffic with periodic flushes
        for (int i = 0; i < 400; i++) begin
            seq = {seq[30:0], seq[31] ^ seq[21] ^ seq[1] ^ seq[0]};
            host_tx_wr_en = seq[0];
            host_tx_wdata = seq ^ 32'h0F0F_0000;
            eng_tx_pop    = seq[3] & seq[5];
            eng_rx_push   = seq[7];
            eng_rx_data   = {seq[15:0], seq[31:16]};
            host_rx_rd_en = seq[9] & seq[11];
            if (i % 37 == 36) begin
                cfg_wr_en = 1;
                cfg_wdata = {seq[20:18], seq[24:22], seq[13], seq[17]};
            end
            step();
        end

        done = 1;
        summary();
    end
endmodule